// File: doc/BRIEF.md
# Fragment Depth, Blend and Fog Pipeline

This block is the per-pixel back end of a fixed-function triangle renderer. Fragments arrive one per cycle through a valid/ready handshake. Each fragment carries a screen position, a depth and an RGBA colour. For every fragment the block reads the stored depth and colour of the target pixel from a synchronous memory port. It keeps the fragment only if it is nearer than what is already stored. It then optionally mixes the fragment with the stored colour using the fragment's alpha, and optionally pulls the result towards a global fog colour by an amount that rises linearly with depth. The final colour and the new depth are written back to the same pixel.

The work is split into overlapping stages:

1. Read issue.
2. Depth compare.
3. Blend.
4. Fog.
5. Write.

While one fragment is blending, the next one is being depth-tested. A fragment that aims at a pixel still owned by an earlier fragment in the pipe is held at the input until that earlier write has landed. This keeps every read-modify-write exact. The enables, fog colour and fog range are configuration inputs, and a counter reports how many fragments the depth test has thrown away.

Top module: `frag_backend`

## Requirements
- R1: A fragment is taken on a rising edge where `in_valid` and `in_ready` are both high. In that same cycle `mem_rd_en` is high and `mem_rd_addr` is `{in_y, in_x}`. Memory data is expected on `mem_rd_z`/`mem_rd_rgb` one cycle later. A run of fragments to distinct pixels is taken at one per cycle with no stall.
- R2: A fragment survives only if its depth is strictly less than the stored depth. A fragment with equal or greater depth produces no write and increments `discard_cnt` by one.
- R3: A surviving fragment writes its own depth and its final colour to its pixel. `mem_wr_en` rises three clock edges after the edge that accepts it.
- R4: The fragment colour is packed as `{R, G, B, A}` with A in the low byte, and stored colour is `{R, G, B}`. With `blend_en` low, the stored colour becomes the fragment RGB and alpha has no effect.
- R5: With `blend_en` high, let w = A + A[7] (range 0..256). Each channel becomes (w·new + (256−w)·old) >> 8, where old is the colour read from memory. A = 255 gives the new colour and A = 0 keeps the old one.
- R6: The fog weight f (range 0..256) is defined in this order: 256 if z ≥ `fog_far`; otherwise 0 if z ≤ `fog_near`; otherwise ((z − `fog_near`)·256) / (`fog_far` − `fog_near`), truncated.
- R7: With `fog_en` high, each channel of the colour after blending becomes (f·fog + (256−f)·c) >> 8. With `fog_en` low, the colour after blending is stored unchanged.
- R8: A fragment whose pixel matches any fragment still in flight is stalled until that write has completed. Two back-to-back fragments to one pixel cost exactly 4 stall cycles, and the memory ends as if fragments were handled one at a time in order.
- R9: After reset `in_ready` is high with an empty pipe, `mem_wr_en` is low and `discard_cnt` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Fragment present |
| in_ready | output | 1 | Fragment can be taken this cycle |
| in_x | input | XW | Screen column |
| in_y | input | YW | Screen row |
| in_z | input | ZW | Fragment depth, smaller is nearer |
| in_rgba | input | 4·CW | Fragment colour {R,G,B,A} |
| blend_en | input | 1 | Enable alpha blend |
| fog_en | input | 1 | Enable depth fog |
| fog_rgb | input | 3·CW | Fog colour {R,G,B} |
| fog_near | input | ZW | Depth where fog starts |
| fog_far | input | ZW | Depth where fog is full |
| mem_rd_en | output | 1 | Pixel read strobe |
| mem_rd_addr | output | XW+YW | Pixel read address {y,x} |
| mem_rd_z | input | ZW | Stored depth, one cycle after read |
| mem_rd_rgb | input | 3·CW | Stored colour, one cycle after read |
| mem_wr_en | output | 1 | Pixel write strobe |
| mem_wr_addr | output | XW+YW | Pixel write address |
| mem_wr_z | output | ZW | Depth to store |
| mem_wr_rgb | output | 3·CW | Colour to store |
| discard_cnt | output | CNTW | Fragments rejected by the depth test |

## Verification
Every pixel of a 16×16 screen is swept in several patterns:

- **Opaque fill and overwrite.** A second overwrite pass mixes nearer, farther and exactly equal depths, which separates the strict depth compare from a less-or-equal compare.
- **Blend sweep.** Alpha runs through 0, 255, 128 and many other values, which shows that the weight reaches both ends exactly.
- **Fog depth ramp.** Depth walks across, onto and beyond both fog limits. A second ramp uses a reversed range, which exercises the clamp ordering.
- **Same-pixel bursts.** Repeated back-to-back fragments to one pixel with blending on would give a wrong colour if the stall were missing or too short. The stall length and the single-fragment write latency are measured as well.

// File: rtl/fbe_pkg.sv
package fbe_pkg;
  // Fractional bits of the fog weight (weight range 0 .. 2**FOG_FB).
  localparam int FOG_FB = 8;
endpackage

// File: rtl/fbe_mix.sv
// Per-channel linear mix: y = (w*a + (ONE-w)*b) >> WF, w in 0..ONE.
module fbe_mix #(
  parameter int CW  = 8,
  parameter int NCH = 3,
  parameter int WF  = 8
) (
  input  logic [WF:0]         w,
  input  logic [NCH*CW-1:0]   a,
  input  logic [NCH*CW-1:0]   b,
  output logic [NCH*CW-1:0]   y
);
  localparam int PW = CW + WF + 2;
  localparam logic [WF:0] ONE = (WF+1)'(1) << WF;

  logic [WF:0] w_inv;
  assign w_inv = ONE - w;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    assign y[ch*CW +: CW] = CW'(((PW'(w) * PW'(a[ch*CW +: CW]))
                               + (PW'(w_inv) * PW'(b[ch*CW +: CW]))) >> WF);
  end
endmodule

// File: rtl/fbe_fog_factor.sv
// Linear fog weight in FB fractional bits, clamped at both ends.
module fbe_fog_factor #(
  parameter int ZW = 16,
  parameter int FB = 8
) (
  input  logic [ZW-1:0] z,
  input  logic [ZW-1:0] z_near,
  input  logic [ZW-1:0] z_far,
  output logic [FB:0]   f
);
  localparam int NW = ZW + FB;
  typedef logic [FB:0] frac_t;

  logic [NW-1:0] num;
  logic [NW-1:0] den;

  assign num = {z - z_near, {FB{1'b0}}};
  assign den = NW'(z_far - z_near);

  always_comb begin
    if (z >= z_far)       f = frac_t'(1) << FB;
    else if (z <= z_near) f = '0;
    else                  f = frac_t'(num / den);
  end
endmodule

// File: rtl/fbe_hazard.sv
// Flags when a probe address matches any valid in-flight address.
module fbe_hazard #(
  parameter int AW = 8,
  parameter int N  = 4
) (
  input  logic [AW-1:0]   probe,
  input  logic [N-1:0]    busy_v,
  input  logic [N*AW-1:0] busy_addr,
  output logic            hit
);
  logic [N-1:0] match;
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign match[i] = busy_v[i] && (busy_addr[i*AW +: AW] == probe);
  end
  assign hit = |match;
endmodule

// File: rtl/frag_backend.sv
module frag_backend #(
  parameter int XW   = 4,
  parameter int YW   = 4,
  parameter int ZW   = 16,
  parameter int CW   = 8,
  parameter int CNTW = 16,
  localparam int AW   = XW + YW,
  localparam int RGBW = 3 * CW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [XW-1:0]     in_x,
  input  logic [YW-1:0]     in_y,
  input  logic [ZW-1:0]     in_z,
  input  logic [4*CW-1:0]   in_rgba,
  input  logic              blend_en,
  input  logic              fog_en,
  input  logic [RGBW-1:0]   fog_rgb,
  input  logic [ZW-1:0]     fog_near,
  input  logic [ZW-1:0]     fog_far,
  output logic              mem_rd_en,
  output logic [AW-1:0]     mem_rd_addr,
  input  logic [ZW-1:0]     mem_rd_z,
  input  logic [RGBW-1:0]   mem_rd_rgb,
  output logic              mem_wr_en,
  output logic [AW-1:0]     mem_wr_addr,
  output logic [ZW-1:0]     mem_wr_z,
  output logic [RGBW-1:0]   mem_wr_rgb,
  output logic [CNTW-1:0]   discard_cnt
);
  import fbe_pkg::*;

  localparam int NBUSY = 4;

  // ---------------- input and hazard ----------------
  logic hazard_hit;
  logic accept;

  // stage 1: memory data returning, depth compare
  logic            s1_v;
  logic [AW-1:0]   s1_addr;
  logic [ZW-1:0]   s1_z;
  logic [4*CW-1:0] s1_rgba;
  logic            depth_pass;

  // stage 2: blend
  logic            s2_v;
  logic [AW-1:0]   s2_addr;
  logic [ZW-1:0]   s2_z;
  logic [4*CW-1:0] s2_rgba;
  logic [RGBW-1:0] s2_dst;
  logic [CW:0]     blend_w;
  logic [RGBW-1:0] blend_y;

  // stage 3: fog
  logic            s3_v;
  logic [AW-1:0]   s3_addr;
  logic [ZW-1:0]   s3_z;
  logic [RGBW-1:0] s3_rgb;
  logic [FOG_FB:0] fog_w;
  logic [RGBW-1:0] fog_y;

  fbe_hazard #(.AW(AW), .N(NBUSY)) u_hazard (
    .probe     ({in_y, in_x}),
    .busy_v    ({mem_wr_en, s3_v, s2_v, s1_v}),
    .busy_addr ({mem_wr_addr, s3_addr, s2_addr, s1_addr}),
    .hit       (hazard_hit)
  );

  assign in_ready    = !hazard_hit;
  assign accept      = in_valid && in_ready;
  assign mem_rd_en   = accept;
  assign mem_rd_addr = {in_y, in_x};

  // ---------------- stage 1 ----------------
  always_ff @(posedge clk) begin
    if (rst) s1_v <= 1'b0;
    else     s1_v <= accept;
    s1_addr <= mem_rd_addr;
    s1_z    <= in_z;
    s1_rgba <= in_rgba;
  end

  assign depth_pass = s1_z < mem_rd_z;

  always_ff @(posedge clk) begin
    if (rst)                     discard_cnt <= '0;
    else if (s1_v && !depth_pass) discard_cnt <= discard_cnt + 1'b1;
  end

  // ---------------- stage 2 ----------------
  always_ff @(posedge clk) begin
    if (rst) s2_v <= 1'b0;
    else     s2_v <= s1_v && depth_pass;
    s2_addr <= s1_addr;
    s2_z    <= s1_z;
    s2_rgba <= s1_rgba;
    s2_dst  <= mem_rd_rgb;
  end

  assign blend_w = {1'b0, s2_rgba[CW-1:0]} + (CW+1)'(s2_rgba[CW-1]);

  fbe_mix #(.CW(CW), .NCH(3), .WF(CW)) u_blend (
    .w (blend_w),
    .a (s2_rgba[4*CW-1:CW]),
    .b (s2_dst),
    .y (blend_y)
  );

  // ---------------- stage 3 ----------------
  always_ff @(posedge clk) begin
    if (rst) s3_v <= 1'b0;
    else     s3_v <= s2_v;
    s3_addr <= s2_addr;
    s3_z    <= s2_z;
    s3_rgb  <= blend_en ? blend_y : s2_rgba[4*CW-1:CW];
  end

  fbe_fog_factor #(.ZW(ZW), .FB(FOG_FB)) u_fogw (
    .z      (s3_z),
    .z_near (fog_near),
    .z_far  (fog_far),
    .f      (fog_w)
  );

  fbe_mix #(.CW(CW), .NCH(3), .WF(FOG_FB)) u_fog (
    .w (fog_w),
    .a (fog_rgb),
    .b (s3_rgb),
    .y (fog_y)
  );

  // ---------------- write stage ----------------
  always_ff @(posedge clk) begin
    if (rst) mem_wr_en <= 1'b0;
    else     mem_wr_en <= s3_v;
    mem_wr_addr <= s3_addr;
    mem_wr_z    <= s3_z;
    mem_wr_rgb  <= fog_en ? fog_y : s3_rgb;
  end

  // ---------------- assertions ----------------
  AST_WR_FROM_READ: assert property (@(posedge clk) disable iff (rst) mem_wr_en |-> ($past(mem_rd_en, 4) && $past(mem_rd_addr, 4) == mem_wr_addr)); // R3
  AST_WR_NEARER: assert property (@(posedge clk) disable iff (rst) mem_wr_en |-> (mem_wr_z < $past(mem_rd_z, 3))); // R2
  AST_DISCARD_STEP: assert property (@(posedge clk) disable iff (rst) (discard_cnt != $past(discard_cnt)) |-> (discard_cnt == $past(discard_cnt) + 1'b1)); // R2
  AST_NO_DUP_12: assert property (@(posedge clk) disable iff (rst) (s1_v && s2_v) |-> (s1_addr != s2_addr)); // R8
  AST_NO_DUP_2W: assert property (@(posedge clk) disable iff (rst) (s2_v && mem_wr_en) |-> (s2_addr != mem_wr_addr)); // R8
  AST_FOG_FULL: assert property (@(posedge clk) disable iff (rst) (fog_en && s3_v && s3_z >= fog_far && $stable(fog_rgb)) |=> (mem_wr_rgb == $past(fog_rgb))); // R6
endmodule

// File: tb/frag_backend_test.sv
module frag_backend_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_ready;
  logic [3:0]  in_x, in_y;
  logic [15:0] in_z;
  logic [31:0] in_rgba;
  logic        blend_en, fog_en;
  logic [23:0] fog_rgb;
  logic [15:0] fog_near, fog_far;
  logic        mem_rd_en;
  logic [7:0]  mem_rd_addr;
  logic [15:0] mem_rd_z;
  logic [23:0] mem_rd_rgb;
  logic        mem_wr_en;
  logic [7:0]  mem_wr_addr;
  logic [15:0] mem_wr_z;
  logic [23:0] mem_wr_rgb;
  logic [15:0] discard_cnt;

  int checks = 0;
  int fails  = 0;
  int stalls = 0;
  int exp_disc = 0;
  int ez [256];
  logic [23:0] ec [256];
  logic [15:0] mz [256];
  logic [23:0] mc [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  frag_backend uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_x(in_x), .in_y(in_y), .in_z(in_z), .in_rgba(in_rgba),
    .blend_en(blend_en), .fog_en(fog_en), .fog_rgb(fog_rgb),
    .fog_near(fog_near), .fog_far(fog_far),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_z(mem_rd_z), .mem_rd_rgb(mem_rd_rgb),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
    .mem_wr_z(mem_wr_z), .mem_wr_rgb(mem_wr_rgb),
    .discard_cnt(discard_cnt)
  );

  // pixel memory model: synchronous read, one cycle latency
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) begin
        mz[i] <= 16'hFFFF;
        mc[i] <= 24'h0;
      end
    end else begin
      if (mem_rd_en) begin
        mem_rd_z   <= mz[mem_rd_addr];
        mem_rd_rgb <= mc[mem_rd_addr];
      end
      if (mem_wr_en) begin
        mz[mem_wr_addr] <= mem_wr_z;
        mc[mem_wr_addr] <= mem_wr_rgb;
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int lerp(int w, int a, int b);
    return (w * a + (256 - w) * b) >> 8;
  endfunction

  // sequential reference for one fragment
  task automatic model(int addr, int z, logic [31:0] rgba);
    int r, g, b, a, w, f;
    if (z < ez[addr]) begin
      r = rgba[31:24]; g = rgba[23:16]; b = rgba[15:8]; a = rgba[7:0];
      if (blend_en) begin // R5
        w = a + (a >> 7);
        r = lerp(w, r, ec[addr][23:16]);
        g = lerp(w, g, ec[addr][15:8]);
        b = lerp(w, b, ec[addr][7:0]);
      end
      if (fog_en) begin // R6 R7
        if (z >= int'(fog_far))       f = 256;
        else if (z <= int'(fog_near)) f = 0;
        else f = ((z - int'(fog_near)) * 256) / (int'(fog_far) - int'(fog_near));
        r = lerp(f, fog_rgb[23:16], r);
        g = lerp(f, fog_rgb[15:8], g);
        b = lerp(f, fog_rgb[7:0], b);
      end
      ez[addr] = z;
      ec[addr] = {r[7:0], g[7:0], b[7:0]};
    end else begin
      exp_disc++;
    end
  endtask

  // called at a falling edge; returns at the falling edge after acceptance
  task automatic send(int addr, int z, logic [31:0] rgba);
    in_valid = 1'b1;
    in_x = addr[3:0]; in_y = addr[7:4];
    in_z = z[15:0]; in_rgba = rgba;
    #1;
    while (!in_ready) begin
      stalls++;
      @(negedge clk); #1;
    end
    @(negedge clk);
    in_valid = 1'b0;
    model(addr, z, rgba);
  endtask

  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b0;
    for (int i = 0; i < 256; i++) begin ez[i] = 32'hFFFF; ec[i] = 24'h0; end
    exp_disc = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic drain_and_compare(string tag);
    repeat (8) @(negedge clk);
    for (int i = 0; i < 256; i++) begin
      chk({tag, " depth"}, 32'(mz[i]), 32'(ez[i]));
      chk({tag, " colour"}, 32'(mc[i]), 32'(ec[i]));
    end
    chk("R2 discard count", 32'(discard_cnt), 32'(exp_disc[15:0]));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n;
    in_x = '0; in_y = '0; in_z = '0; in_rgba = '0;
    blend_en = 1'b0; fog_en = 1'b0; fog_rgb = 24'h4080C0;
    fog_near = 16'd0; fog_far = 16'd1;
    do_reset();

    // R9 reset state
    chk("R9 ready after reset", 32'(in_ready), 32'd1);
    chk("R9 no write after reset", 32'(mem_wr_en), 32'd0);
    chk("R9 counter after reset", 32'(discard_cnt), 32'd0);

    // R3 latency of a single fragment
    send(3, 500, 32'h11223344);
    n = 0;
    while (!mem_wr_en && n < 10) begin @(negedge clk); n++; end
    chk("R3 write latency", 32'(n), 32'd3);
    chk("R3 write depth", 32'(mem_wr_z), 32'd500);
    chk("R4 write colour", 32'(mem_wr_rgb), 32'h112233);

    // R1 distinct pixels stream without stall
    do_reset();
    stalls = 0;
    for (int i = 0; i < 16; i++) send(i * 16 + 1, 100 + i, 32'hA0B0C0FF);
    chk("R1 distinct pixels no stall", 32'(stalls), 32'd0);

    // R8 back-to-back same pixel stalls exactly 4 cycles
    repeat (8) @(negedge clk);
    stalls = 0;
    blend_en = 1'b1;
    send(77, 900, 32'h80808080);
    send(77, 800, 32'h10F02040);
    chk("R8 same pixel stall", 32'(stalls), 32'd4);
    drain_and_compare("R8 pair");
    blend_en = 1'b0;

    // R2 R4: opaque fill, then overwrite with mixed depths
    do_reset();
    for (int i = 0; i < 256; i++)
      send(i, 1000 + (i * 37) % 500, {8'(i * 7), 8'(i * 13), 8'(i * 29), 8'(i * 3)});
    drain_and_compare("R4 fill");
    for (int i = 0; i < 256; i++) begin
      int z2;
      z2 = (i % 16 == 0) ? ez[i] : 900 + (i * 53) % 700;
      send(i, z2, {8'(i * 11), 8'(i * 5), 8'(255 - i), 8'(i)});
    end
    drain_and_compare("R2 overwrite");

    // R5 blend sweep plus R8 same-pixel bursts
    blend_en = 1'b1;
    for (int i = 0; i < 256; i++) begin
      int a;
      case (i % 4)
        0: a = 0;
        1: a = 255;
        2: a = 128;
        default: a = (i * 41) % 256;
      endcase
      send((i * 5) % 256, 500 - (i % 7), {8'(i * 3), 8'(200 - i), 8'(i * 17), 8'(a)});
    end
    drain_and_compare("R5 blend");
    for (int k = 0; k < 32; k++)
      for (int j = 0; j < 3; j++)
        send(k * 7, 300 - j * 10 - k, {8'(k * 8), 8'(j * 90), 8'(255 - k), 8'(60 + j * 70)});
    drain_and_compare("R8 burst");
    blend_en = 1'b0;

    // R6 R7 fog ramp over both limits
    do_reset();
    fog_en = 1'b1; fog_near = 16'd2000; fog_far = 16'd2600; fog_rgb = 24'h4080C0;
    for (int i = 0; i < 256; i++)
      send(i, 1800 + i * 4, {8'(i), 8'(255 - i), 8'(i * 9), 8'h55});
    drain_and_compare("R6 fog ramp");

    // R6 reversed range: clamp order
    do_reset();
    fog_near = 16'd3000; fog_far = 16'd1000; fog_rgb = 24'hF01020;
    for (int i = 0; i < 256; i++)
      send(i, 500 + i * 8, {8'(i * 2), 8'(i), 8'(100), 8'h00});
    drain_and_compare("R6 reversed");

    // R7 blend then fog combined
    do_reset();
    blend_en = 1'b1; fog_near = 16'd100; fog_far = 16'd4000; fog_rgb = 24'h203040;
    for (int i = 0; i < 256; i++)
      send(i, 3000 + (i * 7) % 2000, {8'(i * 13), 8'(i * 31), 8'(i * 5), 8'(i * 19)});
    drain_and_compare("R7 combined fill");
    for (int i = 0; i < 256; i++)
      send(i, 50 + (i * 11) % 3000, {8'(i * 3), 8'(i * 71), 8'(i * 23), 8'(i * 97)});
    drain_and_compare("R7 combined overwrite");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule